// File: doc/BRIEF.md
# Dual-Pump Phase/Frequency Detector Controller

This block compares two synchronous pulse trains, one from a reference divider and one from a main (feedback) divider, and decides in which direction the loop must steer. A rising edge on the reference input sets an "up" decision. A rising edge on the main input sets a "down" decision. Both decisions are driven as commands to two charge pumps at once. The low-current pump follows the decision whenever the block is powered. The high-current speed-up pump follows it only while a fast-mode enable is in force.

The fast-mode request is re-timed to the detector: it is sampled only while no decision is active, so an enable or disable never truncates or starts a pump pulse partway through. The up and down flip-flops are released together only after both have been active for a fixed minimum overlap. Because this release is timed from the low-current pump commands themselves, a zero phase error still yields a short, matched pulse on both pump outputs, which removes the dead zone.

An active-low lock-indicator output is pulled low for exactly as many cycles as the phase error lasts, so external filtering can turn it into an in-lock or out-of-lock flag. A control bit keeps this output released. A power-down input clears the detector, silences every pump command and releases the lock output.

Top module: `pfd_dual_pump`

## Requirements
- R1: After reset all four pump commands are 0 and `lock_n` is 1.
- R2: A rising edge on `ref_in` (0 in one clock, 1 in the next) sets `slow_up` from the following cycle. A rising edge on `div_in` sets `slow_dn` in the same way. A rising edge that arrives while its decision is already set has no effect.
- R3: Once `slow_up` and `slow_dn` are both 1, they stay 1 together for exactly MIN_OVERLAP cycles (2 by default) and are then cleared in the same cycle.
- R4: If both inputs rise in the same cycle, both pump commands pulse for exactly 2 cycles and `lock_n` stays 1.
- R5: `lock_n` is 0 exactly in the cycles in which one of `slow_up`/`slow_dn` is 1 and the other is 0. For a lead of d cycles between the two edges, it is therefore low for d cycles.
- R6: While `lock_dis` is 1, `lock_n` stays 1 whatever the phase error.
- R7: While `pwr_dn` is 0, `slow_up`/`slow_dn` reflect the detector decision in every cycle, independent of fast mode.
- R8: When fast mode is in force, `fast_up`/`fast_dn` equal `slow_up`/`slow_dn`. When it is not in force, both are 0.
- R9: `fast_req` is taken over only at a clock edge at which neither decision is active. A change of `fast_req` during an active pulse does not alter the fast commands until both decisions have cleared.
- R10: While `pwr_dn` is 1, all pump commands are 0 in the same cycle, `lock_n` is 1 and the detector is cleared. After `pwr_dn` falls, no command appears until a new rising edge arrives.
- R11: An input held high produces only one decision. No further command appears until that input has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference divider output, synchronous to clk |
| div_in | input | 1 | Main divider output, synchronous to clk |
| fast_req | input | 1 | Request to enable the high-current pump |
| lock_dis | input | 1 | 1 keeps the lock output released |
| pwr_dn | input | 1 | 1 powers the detector down |
| slow_up | output | 1 | Low-current pump up command |
| slow_dn | output | 1 | Low-current pump down command |
| fast_up | output | 1 | High-current pump up command |
| fast_dn | output | 1 | High-current pump down command |
| lock_n | output | 1 | Active-low phase-error pulse |

## Verification
The hardest situation to reach from the ports is a fast-mode request that changes while a pump pulse is in flight. The bench reaches it by raising only the reference input, so the up decision stays set because no main edge arrives. It then toggles `fast_req` during that open-ended pulse and completes the pulse later with a main edge. The same open-pulse trick places a power-down in the middle of an active decision, while the reference input is held high across the wake-up to show that no stale edge is replayed. A table of edge offsets covers leads in both directions, zero error, the longest lead, and every combination of fast mode and lock disable.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Pair of pump commands produced by one up/down decision
    typedef struct packed {
        logic up;
        logic dn;
    } pump_cmd_t;

    localparam int unsigned DEFAULT_MIN_OVERLAP = 2;

    // Pass a command pair only when the enable is set
    function automatic pump_cmd_t gate_cmd(pump_cmd_t c, logic en);
        pump_cmd_t r;
        r.up = c.up & en;
        r.dn = c.dn & en;
        return r;
    endfunction

    // One side active without the other: the phase error window
    function automatic logic error_window(pump_cmd_t c);
        return c.up ^ c.dn;
    endfunction

    // Neither side active
    function automatic logic cmd_idle(pump_cmd_t c);
        return ~(c.up | c.dn);
    endfunction

endpackage

// File: rtl/pfd_edge_capture.sv
module pfd_edge_capture #(
    parameter int unsigned CHANNELS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] sig_in,
    output logic [CHANNELS-1:0] rise
);
    // Keeps tracking its inputs during power-down, so no stale edge is replayed on wake-up
    logic [CHANNELS-1:0] prev_q;

    for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= sig_in[i];
        end
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int unsigned MIN_OVERLAP = DEFAULT_MIN_OVERLAP
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_dn,
    input  logic      ref_rise,
    input  logic      div_rise,
    output pump_cmd_t state
);
    localparam int unsigned OV_W = (MIN_OVERLAP < 2) ? 1 : $clog2(MIN_OVERLAP + 1);
    localparam logic [OV_W-1:0] OV_LAST = OV_W'(MIN_OVERLAP - 1);

    pump_cmd_t       st_q;
    logic [OV_W-1:0] ov_q;
    logic            both;
    logic            clr;

    // Release is timed from the pump commands themselves: the dead-zone feedback path
    assign both = st_q.up & st_q.dn;
    assign clr  = both & (ov_q == OV_LAST);

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            st_q <= '0;
            ov_q <= '0;
        end else begin
            st_q.up <= ref_rise | (st_q.up & ~clr);
            st_q.dn <= div_rise | (st_q.dn & ~clr);
            ov_q    <= (both && !clr) ? ov_q + 1'b1 : '0;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/pfd_fast_retime.sv
module pfd_fast_retime
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_dn,
    input  logic      fast_req,
    input  pump_cmd_t state,
    output logic      fast_en
);
    logic en_q;

    // Sample the request only between comparison events
    always_ff @(posedge clk) begin
        if (rst || pwr_dn)       en_q <= 1'b0;
        else if (cmd_idle(state)) en_q <= fast_req;
    end

    assign fast_en = en_q;
endmodule

// File: rtl/pfd_lock_drive.sv
module pfd_lock_drive
    import pfd_pkg::*;
(
    input  pump_cmd_t cmd,
    input  logic      lock_dis,
    input  logic      pwr_dn,
    output logic      lock_n
);
    always_comb begin
        lock_n = 1'b1;
        if (!lock_dis && !pwr_dn && error_window(cmd)) lock_n = 1'b0;
    end
endmodule

// File: rtl/pfd_dual_pump.sv
module pfd_dual_pump
    import pfd_pkg::*;
#(
    parameter int unsigned MIN_OVERLAP = DEFAULT_MIN_OVERLAP
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic div_in,
    input  logic fast_req,
    input  logic lock_dis,
    input  logic pwr_dn,
    output logic slow_up,
    output logic slow_dn,
    output logic fast_up,
    output logic fast_dn,
    output logic lock_n
);
    localparam int unsigned N_IN = 2;

    logic [N_IN-1:0] rise;
    pump_cmd_t       state;
    pump_cmd_t       slow_cmd;
    pump_cmd_t       fast_cmd;
    logic            fast_en;

    pfd_edge_capture #(.CHANNELS(N_IN)) u_edges (
        .clk    (clk),
        .rst    (rst),
        .sig_in ({div_in, ref_in}),
        .rise   (rise)
    );

    pfd_core #(.MIN_OVERLAP(MIN_OVERLAP)) u_core (
        .clk      (clk),
        .rst      (rst),
        .pwr_dn   (pwr_dn),
        .ref_rise (rise[0]),
        .div_rise (rise[1]),
        .state    (state)
    );

    pfd_fast_retime u_fast (
        .clk      (clk),
        .rst      (rst),
        .pwr_dn   (pwr_dn),
        .fast_req (fast_req),
        .state    (state),
        .fast_en  (fast_en)
    );

    assign slow_cmd = gate_cmd(state, ~pwr_dn);
    assign fast_cmd = gate_cmd(slow_cmd, fast_en);

    pfd_lock_drive u_lock (
        .cmd      (slow_cmd),
        .lock_dis (lock_dis),
        .pwr_dn   (pwr_dn),
        .lock_n   (lock_n)
    );

    assign slow_up = slow_cmd.up;
    assign slow_dn = slow_cmd.dn;
    assign fast_up = fast_cmd.up;
    assign fast_dn = fast_cmd.dn;
endmodule

// File: rtl/pfd_dual_pump_checker.sv
module pfd_dual_pump_checker (
    input logic clk,
    input logic rst,
    input logic ref_in,
    input logic div_in,
    input logic fast_req,
    input logic lock_dis,
    input logic pwr_dn,
    input logic slow_up,
    input logic slow_dn,
    input logic fast_up,
    input logic fast_dn,
    input logic lock_n
);
    // R3: two overlapping cycles with no fresh edge end in a joint release
    a_r3_joint_clear: assert property (@(posedge clk) disable iff (rst)
        (slow_up && slow_dn && $past(slow_up && slow_dn) && !pwr_dn && !$past(pwr_dn)
         && !(ref_in && !$past(ref_in)) && !(div_in && !$past(div_in)))
        |=> (!slow_up && !slow_dn));

    // R5: a low lock output means exactly one side is active
    a_r5_lock_is_error: assert property (@(posedge clk) disable iff (rst)
        !lock_n |-> (slow_up != slow_dn));

    // R6: disabled lock output stays released
    a_r6_lock_disabled: assert property (@(posedge clk) disable iff (rst)
        lock_dis |-> lock_n);

    // R8: a fast command never appears without its slow counterpart
    a_r8_fast_subset: assert property (@(posedge clk) disable iff (rst)
        (fast_up |-> slow_up) and (fast_dn |-> slow_dn));

    // R9: fast gating does not change while an up pulse continues
    a_r9_no_midpulse_change: assert property (@(posedge clk) disable iff (rst)
        (slow_up && $past(slow_up) && !pwr_dn && !$past(pwr_dn)) |-> (fast_up == $past(fast_up)));

    // R10: power-down silences everything
    a_r10_power_down: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |-> (!slow_up && !slow_dn && !fast_up && !fast_dn && lock_n));
endmodule

bind pfd_dual_pump pfd_dual_pump_checker u_chk (.*);

// File: tb/tb_pfd_dual_pump.sv
`timescale 1ns/1ps
module tb_pfd_dual_pump;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0, div_in = 1'b0, fast_req = 1'b0, lock_dis = 1'b0, pwr_dn = 1'b0;
    logic slow_up, slow_dn, fast_up, fast_dn, lock_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfd_dual_pump dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .div_in(div_in),
        .fast_req(fast_req), .lock_dis(lock_dis), .pwr_dn(pwr_dn),
        .slow_up(slow_up), .slow_dn(slow_dn), .fast_up(fast_up),
        .fast_dn(fast_dn), .lock_n(lock_n)
    );

    typedef struct packed {
        logic [3:0] ref_off;
        logic [3:0] div_off;
        logic       fst;
        logic       ldis;
        logic [4:0] e_up;
        logic [4:0] e_dn;
        logic [4:0] e_lock;
        logic [4:0] e_fup;
        logic [4:0] e_fdn;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 4'd0, 1'b0, 1'b0, 5'd2,  5'd2, 5'd0, 5'd0,  5'd0},
        '{4'd0, 4'd3, 1'b0, 1'b0, 5'd5,  5'd2, 5'd3, 5'd0,  5'd0},
        '{4'd4, 4'd0, 1'b0, 1'b0, 5'd2,  5'd6, 5'd4, 5'd0,  5'd0},
        '{4'd1, 4'd6, 1'b1, 1'b0, 5'd7,  5'd2, 5'd5, 5'd7,  5'd2},
        '{4'd5, 4'd2, 1'b1, 1'b0, 5'd2,  5'd5, 5'd3, 5'd2,  5'd5},
        '{4'd0, 4'd4, 1'b0, 1'b1, 5'd6,  5'd2, 5'd0, 5'd0,  5'd0},
        '{4'd2, 4'd2, 1'b1, 1'b1, 5'd2,  5'd2, 5'd0, 5'd2,  5'd2},
        '{4'd0, 4'd8, 1'b1, 1'b0, 5'd10, 5'd2, 5'd8, 5'd10, 5'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        int cu, cd, cl, cfu, cfd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!slow_up && !slow_dn && !fast_up && !fast_dn, "R1 cmds", {slow_up, slow_dn, fast_up, fast_dn}, 0);
        check(lock_n == 1'b1, "R1 lock_n", lock_n, 1);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R11 (inputs held high across the window)
        for (int v = 0; v < NV; v++) begin
            fast_req = VECS[v].fst;
            lock_dis = VECS[v].ldis;
            repeat (2) @(negedge clk);
            cu = 0; cd = 0; cl = 0; cfu = 0; cfd = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                cu  += int'(slow_up);
                cd  += int'(slow_dn);
                cl  += int'(!lock_n);
                cfu += int'(fast_up);
                cfd += int'(fast_dn);
                ref_in = (c >= int'(VECS[v].ref_off));
                div_in = (c >= int'(VECS[v].div_off));
            end
            check(cu == int'(VECS[v].e_up), "R2/R3/R7/R11 up cycles", cu, int'(VECS[v].e_up));
            check(cd == int'(VECS[v].e_dn), "R2/R3/R7/R11 dn cycles", cd, int'(VECS[v].e_dn));
            check(cl == int'(VECS[v].e_lock), "R5/R6/R4 lock low cycles", cl, int'(VECS[v].e_lock));
            check(cfu == int'(VECS[v].e_fup), "R8 fast up cycles", cfu, int'(VECS[v].e_fup));
            check(cfd == int'(VECS[v].e_fdn), "R8 fast dn cycles", cfd, int'(VECS[v].e_fdn));
            @(negedge clk);
            ref_in = 1'b0;
            div_in = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R9: fast request raised during an open up pulse
        fast_req = 1'b0;
        lock_dis = 1'b0;
        repeat (2) @(negedge clk);
        ref_in = 1'b1;
        @(negedge clk);
        check(slow_up && !slow_dn, "R2 up alone", {slow_up, slow_dn}, 2);
        check(!fast_up, "R9 fast off at start", fast_up, 0);
        fast_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(slow_up && !fast_up, "R9 no mid-pulse enable", fast_up, 0);
        end
        div_in = 1'b1;
        @(negedge clk);
        check(slow_dn && !fast_dn && !fast_up, "R9 still off until idle", {fast_up, fast_dn}, 0);
        repeat (3) @(negedge clk);
        check(!slow_up && !slow_dn, "R3 cleared", {slow_up, slow_dn}, 0);
        ref_in = 1'b0;
        div_in = 1'b0;
        repeat (2) @(negedge clk);
        ref_in = 1'b1;
        div_in = 1'b1;
        @(negedge clk);
        check(fast_up && fast_dn, "R8/R9 enable taken when idle", {fast_up, fast_dn}, 3);
        check(lock_n, "R4 zero error keeps lock high", lock_n, 1);
        repeat (3) @(negedge clk);
        ref_in = 1'b0;
        div_in = 1'b0;
        repeat (2) @(negedge clk);

        // R10: power-down in the middle of an up pulse
        ref_in = 1'b1;
        @(negedge clk);
        check(slow_up && !lock_n, "R5 lock low on error", lock_n, 0);
        pwr_dn = 1'b1;
        #1;
        check(!slow_up && !slow_dn && !fast_up && !fast_dn, "R10 cmds off", {slow_up, slow_dn, fast_up, fast_dn}, 0);
        check(lock_n, "R10 lock released", lock_n, 1);
        repeat (3) @(negedge clk);
        pwr_dn = 1'b0;
        cu = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cu += int'(slow_up | slow_dn | fast_up);
        end
        check(cu == 0, "R10/R11 no command after wake with input held", cu, 0);
        // R11: a new edge is needed
        ref_in = 1'b0;
        @(negedge clk);
        ref_in = 1'b1;
        @(negedge clk);
        check(slow_up, "R11 new edge sets up", slow_up, 1);
        check(fast_up, "R8 fast follows after wake", fast_up, 1);
        div_in = 1'b1;
        repeat (4) @(negedge clk);
        check(!slow_up && !slow_dn, "R3 cleared after wake", {slow_up, slow_dn}, 0);

        done = 1'b1;
        finish_run();
    end
endmodule